// File: doc/BRIEF.md
# PLL Ratio Reprogramming and Power Sequencer

This block moves an external analog PLL between operating points without ever exposing downstream logic to an unstable clock. It runs from the reference clock. A host issues one-cycle requests: either a reprogram, which carries new pre-divider, multiplier and post-divider values, or a power-down. The block then walks the PLL through a fixed, timed sequence on its control outputs. Those outputs are the clock mux select (reference or PLL), the PLL reset, the PLL power-down control, and the three ratio values.

A reprogram always takes the same steps. First it selects the reference clock and lets the mux settle. Next it holds the PLL in reset while loading the new ratios. Then it releases reset and waits for lock. Only after that does it hand the clock back to the PLL. A power-down selects the reference clock, lets the mux settle, and then powers the PLL off. A reprogram request issued while powered down acts as a wakeup: it first clears the power-down control and then runs the full reprogram sequence. The reset hold is given in microseconds. It is converted to reference cycles from a reference frequency parameter in kHz, and the cycles per microsecond are rounded up.

Top module: `pll_reseq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `sel_ref`=1 (reference clock selected), `pll_reset`=1, `pll_pwrdn`=0, `busy`=0, `done`=0, and all ratio outputs are zero.
- R2: A request (`req_go`=1 at a clock edge) is accepted when the block is idle or powered down. From the next cycle `busy`=1 and `sel_ref`=1.
- R3: On a reprogram, `pll_reset` rises exactly SETTLE_CYC cycles after the accepting edge. `sel_ref` is 1 throughout that window.
- R4: The ratio outputs change only at the edge where `pll_reset` is asserted in a sequence. They take the values present on `req_pre`/`req_mul`/`req_post` at the accepting edge, and later input changes have no effect.
- R5: `pll_reset` stays high for exactly HOLD_US × ceil(REF_KHZ/1000) cycles before it is released.
- R6: After reset release, `sel_ref` stays 1 for exactly LOCK_CYC cycles (default 8000) and then drops to 0 (PLL clock selected).
- R7: `done` is high for exactly one cycle, in the same cycle that `busy` first reads 0 at the end of an operation.
- R8: A power-down request (`req_op`=1) sets `pll_pwrdn`=1 exactly SETTLE_CYC cycles after acceptance. `sel_ref` stays 1, `pll_reset` and the ratios are left unchanged, and `done` pulses.
- R9: A reprogram request (`req_op`=0) while powered down clears `pll_pwrdn` in the first cycle after acceptance. It then follows R3–R7.
- R10: `req_go` while `busy`=1 has no effect on any output. A power-down request while already powered down has no effect.
- R11: A synchronous `rst` during an operation aborts it and returns all outputs to the R1 state in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| req_go | input | 1 | One-cycle request strobe |
| req_op | input | 1 | 0 = reprogram / wakeup, 1 = power down |
| req_pre | input | PRE_W | Requested pre-divider value |
| req_mul | input | MUL_W | Requested multiplier value |
| req_post | input | POST_W | Requested post-divider value |
| sel_ref | output | 1 | 1 = clock mux takes reference, 0 = PLL output |
| pll_reset | output | 1 | PLL reset control |
| pll_pwrdn | output | 1 | PLL power-down control |
| div_pre | output | PRE_W | Applied pre-divider |
| div_mult | output | MUL_W | Applied multiplier |
| div_post | output | POST_W | Applied post-divider |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses a reduced configuration with narrow ratio fields and short lock and hold windows. It reprograms through every combination of the seven ratio bits. On each cycle of each sequence it compares every output against a cycle-indexed model, so any shift in the settle, hold or lock boundary shows up as an off-by-one mismatch. A 2.5 MHz reference setting makes the microsecond rounding visible, since rounding down would shorten the hold. Power-down and wakeup rounds recur through the sweep. Some requests are followed by a conflicting request while busy, and the ratio inputs are scrambled after every acceptance, to separate captured values from live inputs. A reset issued in the middle of an operation checks that the sequence aborts.

// File: rtl/pll_reseq_pkg.sv
package pll_reseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETTLE = 3'd1,
      ST_HOLD   = 3'd2,
      ST_LOCK   = 3'd3,
      ST_OFF    = 3'd4
   } seq_state_t;

   localparam logic OP_REPROG = 1'b0;
   localparam logic OP_PWRDN  = 1'b1;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pll_reseq_tick.sv
module pll_reseq_tick #(
   parameter int CYC_PER_US = 25
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   output logic tick
);

   generate
      if (CYC_PER_US <= 1) begin : g_every_cycle
         logic unused_tick_in;
         assign unused_tick_in = ^{clk, rst, clr};
         assign tick = 1'b1;
      end else begin : g_prescale
         localparam int PW = $clog2(CYC_PER_US);
         localparam logic [PW-1:0] LAST = PW'(CYC_PER_US - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (rst || clr) begin
               pre_q <= '0;
            end else if (pre_q == LAST) begin
               pre_q <= '0;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end

         assign tick = (pre_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/pll_reseq_wait.sv
module pll_reseq_wait #(
   parameter int CW = 13
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ld,
   input  logic [CW-1:0] ld_val,
   input  logic          en,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (ld) begin
         cnt_q <= ld_val;
      end else if (en && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/pll_reseq_ctrl.sv
module pll_reseq_ctrl
   import pll_reseq_pkg::*;
#(
   parameter int PRE_W      = 5,
   parameter int MUL_W      = 8,
   parameter int POST_W     = 5,
   parameter int CW         = 13,
   parameter int SETTLE_CYC = 4,
   parameter int HOLD_US    = 5,
   parameter int LOCK_CYC   = 8000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_go,
   input  logic              req_op,
   input  logic [PRE_W-1:0]  req_pre,
   input  logic [MUL_W-1:0]  req_mul,
   input  logic [POST_W-1:0] req_post,
   input  logic              tick,
   input  logic              w_zero,
   output logic              w_ld,
   output logic [CW-1:0]     w_val,
   output logic              w_en,
   output logic              t_clr,
   output logic              sel_ref,
   output logic              pll_reset,
   output logic              pll_pwrdn,
   output logic [PRE_W-1:0]  div_pre,
   output logic [MUL_W-1:0]  div_mult,
   output logic [POST_W-1:0] div_post,
   output logic              busy,
   output logic              done
);

   localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC - 1);
   localparam logic [CW-1:0] HOLD_LD   = CW'(HOLD_US - 1);
   localparam logic [CW-1:0] LOCK_LD   = CW'(LOCK_CYC - 1);

   seq_state_t        state_q;
   logic              pd_op_q;
   logic [PRE_W-1:0]  pend_pre_q;
   logic [MUL_W-1:0]  pend_mul_q;
   logic [POST_W-1:0] pend_post_q;

   logic accept_idle, accept_off, enter_hold, leave_hold, leave_lock, leave_settle;

   always_comb begin
      accept_idle  = (state_q == ST_IDLE) && req_go;
      accept_off   = (state_q == ST_OFF) && req_go && (req_op == OP_REPROG);
      leave_settle = (state_q == ST_SETTLE) && w_zero;
      enter_hold   = leave_settle && !pd_op_q;
      leave_hold   = (state_q == ST_HOLD) && tick && w_zero;
      leave_lock   = (state_q == ST_LOCK) && w_zero;
   end

   always_comb begin
      w_ld  = 1'b0;
      w_val = '0;
      if (accept_idle || accept_off) begin
         w_ld  = 1'b1;
         w_val = SETTLE_LD;
      end else if (enter_hold) begin
         w_ld  = 1'b1;
         w_val = HOLD_LD;
      end else if (leave_hold) begin
         w_ld  = 1'b1;
         w_val = LOCK_LD;
      end
      w_en  = (state_q == ST_HOLD) ? tick : 1'b1;
      t_clr = enter_hold;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_IDLE;
         pd_op_q     <= 1'b0;
         sel_ref     <= 1'b1;
         pll_reset   <= 1'b1;
         pll_pwrdn   <= 1'b0;
         done        <= 1'b0;
         div_pre     <= '0;
         div_mult    <= '0;
         div_post    <= '0;
         pend_pre_q  <= '0;
         pend_mul_q  <= '0;
         pend_post_q <= '0;
      end else begin
         done <= 1'b0;
         if (accept_idle || accept_off) begin
            pend_pre_q  <= req_pre;
            pend_mul_q  <= req_mul;
            pend_post_q <= req_post;
         end
         unique case (state_q)
            ST_IDLE: begin
               if (accept_idle) begin
                  sel_ref <= 1'b1;
                  pd_op_q <= req_op;
                  state_q <= ST_SETTLE;
               end
            end
            ST_OFF: begin
               if (accept_off) begin
                  pll_pwrdn <= 1'b0;
                  pd_op_q   <= OP_REPROG;
                  state_q   <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (leave_settle) begin
                  if (pd_op_q) begin
                     pll_pwrdn <= 1'b1;
                     done      <= 1'b1;
                     state_q   <= ST_OFF;
                  end else begin
                     pll_reset <= 1'b1;
                     div_pre   <= pend_pre_q;
                     div_mult  <= pend_mul_q;
                     div_post  <= pend_post_q;
                     state_q   <= ST_HOLD;
                  end
               end
            end
            ST_HOLD: begin
               if (leave_hold) begin
                  pll_reset <= 1'b0;
                  state_q   <= ST_LOCK;
               end
            end
            ST_LOCK: begin
               if (leave_lock) begin
                  sel_ref <= 1'b0;
                  done    <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q == ST_SETTLE) || (state_q == ST_HOLD) || (state_q == ST_LOCK);

endmodule

// File: rtl/pll_reseq.sv
module pll_reseq
   import pll_reseq_pkg::*;
#(
   parameter int PRE_W      = 5,
   parameter int MUL_W      = 8,
   parameter int POST_W     = 5,
   parameter int REF_KHZ    = 25000,
   parameter int HOLD_US    = 5,
   parameter int SETTLE_CYC = 4,
   parameter int LOCK_CYC   = 8000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_go,
   input  logic              req_op,
   input  logic [PRE_W-1:0]  req_pre,
   input  logic [MUL_W-1:0]  req_mul,
   input  logic [POST_W-1:0] req_post,
   output logic              sel_ref,
   output logic              pll_reset,
   output logic              pll_pwrdn,
   output logic [PRE_W-1:0]  div_pre,
   output logic [MUL_W-1:0]  div_mult,
   output logic [POST_W-1:0] div_post,
   output logic              busy,
   output logic              done
);

   localparam int CYC_PER_US = ceil_div(REF_KHZ, 1000);
   localparam int HOLD_CYC   = HOLD_US * CYC_PER_US;
   localparam int CW         = $clog2(max3(SETTLE_CYC, HOLD_US, LOCK_CYC) + 1);

   generate
      if (SETTLE_CYC < 4) begin : g_bad_settle
         $error("pll_reseq: SETTLE_CYC must be at least 4");
      end
      if (HOLD_US < 5) begin : g_bad_hold
         $error("pll_reseq: HOLD_US must be at least 5");
      end
      if (LOCK_CYC < 1) begin : g_bad_lock
         $error("pll_reseq: LOCK_CYC must be positive");
      end
      if (REF_KHZ < 1) begin : g_bad_freq
         $error("pll_reseq: REF_KHZ must be positive");
      end
      if ((PRE_W < 1) || (MUL_W < 1) || (POST_W < 1)) begin : g_bad_width
         $error("pll_reseq: ratio widths must be positive");
      end
   endgenerate

   logic          tick, t_clr, w_ld, w_en, w_zero;
   logic [CW-1:0] w_val;

   pll_reseq_tick #(
      .CYC_PER_US (CYC_PER_US)
   ) u_tick (
      .clk  (clk),
      .rst  (rst),
      .clr  (t_clr),
      .tick (tick)
   );

   pll_reseq_wait #(
      .CW (CW)
   ) u_wait (
      .clk    (clk),
      .rst    (rst),
      .ld     (w_ld),
      .ld_val (w_val),
      .en     (w_en),
      .zero   (w_zero)
   );

   pll_reseq_ctrl #(
      .PRE_W      (PRE_W),
      .MUL_W      (MUL_W),
      .POST_W     (POST_W),
      .CW         (CW),
      .SETTLE_CYC (SETTLE_CYC),
      .HOLD_US    (HOLD_US),
      .LOCK_CYC   (LOCK_CYC)
   ) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .req_go    (req_go),
      .req_op    (req_op),
      .req_pre   (req_pre),
      .req_mul   (req_mul),
      .req_post  (req_post),
      .tick      (tick),
      .w_zero    (w_zero),
      .w_ld      (w_ld),
      .w_val     (w_val),
      .w_en      (w_en),
      .t_clr     (t_clr),
      .sel_ref   (sel_ref),
      .pll_reset (pll_reset),
      .pll_pwrdn (pll_pwrdn),
      .div_pre   (div_pre),
      .div_mult  (div_mult),
      .div_post  (div_post),
      .busy      (busy),
      .done      (done)
   );

endmodule

// File: rtl/pll_reseq_chk.sv
module pll_reseq_chk #(
   parameter int PRE_W      = 5,
   parameter int MUL_W      = 8,
   parameter int POST_W     = 5,
   parameter int SETTLE_CYC = 4,
   parameter int HOLD_CYC   = 125,
   parameter int LOCK_CYC   = 8000
) (
   input logic              clk,
   input logic              rst,
   input logic              sel_ref,
   input logic              pll_reset,
   input logic              pll_pwrdn,
   input logic [PRE_W-1:0]  div_pre,
   input logic [MUL_W-1:0]  div_mult,
   input logic [POST_W-1:0] div_post,
   input logic              busy,
   input logic              done
);

   localparam int CAP = 32'h3FFF_FFFF;

   int byp_run, rst_run, lck_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         byp_run <= 0;
         rst_run <= 0;
         lck_run <= 0;
      end else begin
         byp_run <= sel_ref ? ((byp_run < CAP) ? byp_run + 1 : byp_run) : 0;
         rst_run <= pll_reset ? ((rst_run < CAP) ? rst_run + 1 : rst_run) : 0;
         lck_run <= (!pll_reset && !pll_pwrdn) ? ((lck_run < CAP) ? lck_run + 1 : lck_run) : 0;
      end
   end

   a_r3_settle_before_reset: assert property (@(posedge clk) disable iff (rst)
      $rose(pll_reset) |-> sel_ref && (byp_run >= SETTLE_CYC));

   a_r8_settle_before_pwrdn: assert property (@(posedge clk) disable iff (rst)
      $rose(pll_pwrdn) |-> sel_ref && (byp_run >= SETTLE_CYC));

   a_r8_pwrdn_on_ref: assert property (@(posedge clk) disable iff (rst)
      pll_pwrdn |-> sel_ref);

   a_r4_ratio_gate: assert property (@(posedge clk) disable iff (rst)
      !$stable({div_pre, div_mult, div_post}) |-> pll_reset && sel_ref && !pll_pwrdn);

   a_r5_hold_length: assert property (@(posedge clk) disable iff (rst)
      $fell(pll_reset) |-> (rst_run >= HOLD_CYC));

   a_r6_lock_wait: assert property (@(posedge clk) disable iff (rst)
      $fell(sel_ref) |-> !pll_reset && !pll_pwrdn && (lck_run >= LOCK_CYC));

   a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

endmodule

bind pll_reseq pll_reseq_chk #(
   .PRE_W      (PRE_W),
   .MUL_W      (MUL_W),
   .POST_W     (POST_W),
   .SETTLE_CYC (SETTLE_CYC),
   .HOLD_CYC   (HOLD_CYC),
   .LOCK_CYC   (LOCK_CYC)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .sel_ref   (sel_ref),
   .pll_reset (pll_reset),
   .pll_pwrdn (pll_pwrdn),
   .div_pre   (div_pre),
   .div_mult  (div_mult),
   .div_post  (div_post),
   .busy      (busy),
   .done      (done)
);

// File: tb/test_pll_reseq.sv
`timescale 1ns/1ps
module test_pll_reseq;

   localparam int PW   = 2;
   localparam int MW   = 3;
   localparam int QW   = 2;
   localparam int KHZ  = 2500;
   localparam int HUS  = 5;
   localparam int SET  = 4;
   localparam int LCK  = 40;
   localparam int CPU  = (KHZ + 999) / 1000;
   localparam int HOLD = HUS * CPU;

   logic          clk = 1'b0;
   logic          rst;
   logic          req_go, req_op;
   logic [PW-1:0] req_pre;
   logic [MW-1:0] req_mul;
   logic [QW-1:0] req_post;
   logic          sel_ref, pll_reset, pll_pwrdn, busy, done;
   logic [PW-1:0] div_pre;
   logic [MW-1:0] div_mult;
   logic [QW-1:0] div_post;

   always #2 clk = ~clk;

   pll_reseq #(
      .PRE_W (PW), .MUL_W (MW), .POST_W (QW),
      .REF_KHZ (KHZ), .HOLD_US (HUS), .SETTLE_CYC (SET), .LOCK_CYC (LCK)
   ) i_pll_reseq (
      .clk (clk), .rst (rst), .req_go (req_go), .req_op (req_op),
      .req_pre (req_pre), .req_mul (req_mul), .req_post (req_post),
      .sel_ref (sel_ref), .pll_reset (pll_reset), .pll_pwrdn (pll_pwrdn),
      .div_pre (div_pre), .div_mult (div_mult), .div_post (div_post),
      .busy (busy), .done (done)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   int m_rst, m_pdn, m_pre, m_mul, m_post;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++;
         $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   task automatic check_all(input int e_byp, input int e_rst, input int e_pdn,
                            input int e_pre, input int e_mul, input int e_post,
                            input int e_busy, input int e_done);
      chk("R6", "sel_ref",   32'(sel_ref),   e_byp);
      chk("R5", "pll_reset", 32'(pll_reset), e_rst);
      chk("R8", "pll_pwrdn", 32'(pll_pwrdn), e_pdn);
      chk("R4", "div_pre",   32'(div_pre),   e_pre);
      chk("R4", "div_mult",  32'(div_mult),  e_mul);
      chk("R4", "div_post",  32'(div_post),  e_post);
      chk("R2", "busy",      32'(busy),      e_busy);
      chk("R7", "done",      32'(done),      e_done);
   endtask

   task automatic do_op(input bit pd, input int pv, input int mv, input int qv, input bit inject);
      int end_k, e_byp, e_rst, e_pdn, e_pre, e_mul, e_post;
      bit wake;
      wake  = (m_pdn != 0);
      end_k = pd ? SET : SET + HOLD + LCK;
      @(negedge clk);
      req_go   = 1'b1;
      req_op   = pd;
      req_pre  = PW'(pv);
      req_mul  = MW'(mv);
      req_post = QW'(qv);
      @(posedge clk);
      @(negedge clk);
      req_go   = 1'b0;
      req_pre  = ~PW'(pv);
      req_mul  = ~MW'(mv);
      req_post = ~QW'(qv);
      for (int k = 0; k <= end_k + 1; k++) begin
         if (k > 0) begin
            @(posedge clk);
            @(negedge clk);
         end
         if (pd) begin
            e_byp = 1; e_rst = m_rst; e_pdn = (k >= SET) ? 1 : 0;
            e_pre = m_pre; e_mul = m_mul; e_post = m_post;
         end else begin
            e_byp = (k < end_k) ? 1 : 0;
            e_rst = (k < SET) ? m_rst : ((k < SET + HOLD) ? 1 : 0);
            e_pdn = 0;
            e_pre  = (k < SET) ? m_pre  : pv;
            e_mul  = (k < SET) ? m_mul  : mv;
            e_post = (k < SET) ? m_post : qv;
         end
         check_all(e_byp, e_rst, e_pdn, e_pre, e_mul, e_post,
                   (k < end_k) ? 1 : 0, (k == end_k) ? 1 : 0);
         if (k == SET) begin
            if (pd) chk("R3", "pll_pwrdn at settle end", 32'(pll_pwrdn), 1);
            else    chk("R3", "pll_reset at settle end", 32'(pll_reset), 1);
         end
         if (wake && (k == 0)) chk("R9", "pll_pwrdn released on wake", 32'(pll_pwrdn), 0);
         if (inject && (k == 2)) begin
            req_go   = 1'b1;
            req_op   = ~pd;
            req_pre  = PW'(pv + 1);
            req_mul  = MW'(mv + 3);
            req_post = QW'(qv + 1);
         end else if (inject && (k == 3)) begin
            req_go = 1'b0;
            chk("R10", "busy after request while busy", 32'(busy), (3 < end_k) ? 1 : 0);
         end
      end
      if (pd) begin
         m_pdn = 1;
      end else begin
         m_rst = 0; m_pdn = 0; m_pre = pv; m_mul = mv; m_post = qv;
      end
   endtask

   task automatic ignored_pd;
      @(negedge clk);
      req_go = 1'b1;
      req_op = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_go = 1'b0;
      for (int k = 0; k < 6; k++) begin
         chk("R10", "busy on powerdown while off", 32'(busy), 0);
         chk("R10", "done on powerdown while off", 32'(done), 0);
         chk("R10", "pll_pwrdn stays set", 32'(pll_pwrdn), 1);
         chk("R10", "sel_ref stays on reference", 32'(sel_ref), 1);
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check_reset_state(input string req);
      chk(req, "sel_ref",   32'(sel_ref),   1);
      chk(req, "pll_reset", 32'(pll_reset), 1);
      chk(req, "pll_pwrdn", 32'(pll_pwrdn), 0);
      chk(req, "busy",      32'(busy),      0);
      chk(req, "done",      32'(done),      0);
      chk(req, "ratios",    32'({div_pre, div_mult, div_post}), 0);
   endtask

   initial begin
      rst = 1'b1; req_go = 1'b0; req_op = 1'b0;
      req_pre = '0; req_mul = '0; req_post = '0;
      m_rst = 1; m_pdn = 0; m_pre = 0; m_mul = 0; m_post = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_reset_state("R1");
      rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check_reset_state("R1");

      // R2..R7 sweep over every ratio combination, with R8/R9 rounds mixed in
      for (int v = 0; v < (1 << (PW + MW + QW)); v++) begin
         do_op(1'b0, v & 3, (v >> 2) & 7, (v >> 5) & 3, (v % 8) == 3);
         if ((v % 32) == 31) begin
            do_op(1'b1, 0, 0, 0, (v % 64) == 63);
            ignored_pd();
         end
      end

      // R11: abort in the middle of the hold window
      @(negedge clk);
      req_go = 1'b1; req_op = 1'b0; req_pre = 2'd1; req_mul = 3'd5; req_post = 2'd2;
      @(posedge clk);
      @(negedge clk);
      req_go = 1'b0;
      repeat (SET + 2) begin
         @(posedge clk);
         @(negedge clk);
      end
      chk("R11", "pll_reset before abort", 32'(pll_reset), 1);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check_reset_state("R11");
      m_rst = 1; m_pdn = 0; m_pre = 0; m_mul = 0; m_post = 0;
      do_op(1'b0, 3, 6, 1, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule